// File: doc/BRIEF.md
# Low-Frequency Reader Front End

This block turns one fast master clock into the timing set of a low-frequency inductive reader. It divides the master clock into a serial clock, from that a carrier drive for the coil drivers, and from that a conversion clock for an external 8-bit ADC. A select input chooses one of two integer division ratios, and so one of two carrier frequencies.

On every rising edge of the conversion clock the block takes the ADC bus into its shift register. It then sends the sample out most significant bit first on a serial data line, framed by a strobe. Serial data changes only on falling serial clock edges, so a receiver can sample it on rising edges.

Every generated clock is a register in the master clock domain. An 8-bit divisor input is accepted in the range 16 to 255 and has no effect on the outputs in this fixed-ratio mode. A high-side drive output is held low, and a debug output mirrors the conversion clock.

Top module: `lf_reader_front`

## Requirements
- R1: The serial clock is high for exactly 11+sel master cycles and low for exactly 11+sel master cycles. sel is `sel_125k`: 1 gives a 24-cycle period and 0 gives a 22-cycle period. sel is changed only while reset is held.
- R2: The carrier drive has a period of 8 serial clock periods and is high for 4 of them. It changes only on a master edge where the serial clock falls.
- R3: The ADC clock has a period of 16 serial clock periods. It rises on a falling serial clock edge and stays high for 8 serial clock periods.
- R4: The frame strobe rises on the same master edge as the ADC clock. It stays high for exactly the 8 serial clock periods in which the 8 bits are presented, and it is low at the next rising serial clock edge.
- R5: The ADC bus value present at the rising edge of the ADC clock is sent most significant bit first, one bit per serial clock period. Each bit changes on a falling serial clock edge and is read on the following rising edge. Serial data is low whenever the frame strobe is low.
- R6: A change on the ADC bus after the capture edge does not alter the word being sent.
- R7: `carrier_hi` is low at every cycle.
- R8: `dbg_adc_clk` equals `adc_clk` at every cycle.
- R9: The divisor input takes any value from 16 to 255, and its value changes no output.
- R10: Reset is synchronous and active high. It drives the serial clock, carrier, ADC clock, frame strobe and serial data low. Counting the first master edge with reset low as edge 1, the serial clock rises at edge 11+sel, and the ADC clock and frame strobe rise at edge 2*(11+sel), presenting the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_d | input | 8 | Sample bus from the external ADC |
| sel_125k | input | 1 | Ratio select: 1 for the slower carrier, 0 for the faster |
| divisor | input | 8 | Divisor setting, 16 to 255, no effect in this mode |
| carrier_lo | output | 1 | Carrier drive to the coil drivers |
| carrier_hi | output | 1 | High-side drive, held low |
| adc_clk | output | 1 | Conversion clock for the ADC |
| ser_clk | output | 1 | Serial port clock |
| ser_frame | output | 1 | Frame strobe, high while a word is shifted |
| ser_data | output | 1 | Serial data, most significant bit first |
| dbg_adc_clk | output | 1 | Debug copy of the ADC clock |

## Verification
The properties assume that the ratio select stays constant while reset is low. They also assume that the divisor never goes below 16. The stimulus changes the select and the divisor only inside a reset pulse, so each run starts from cleared dividers with a fixed ratio. The ADC bus is deliberately changed right after every capture edge, which is inside the span the serial clock and frame checks cover.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  // smallest divisor setting the block accepts
  localparam int LFR_DIV_MIN = 16;
endpackage

// File: rtl/lfr_sclk_gen.sv
// Serial clock divider: half period of BASE_HALF + sel master cycles.
module lfr_sclk_gen #(
  parameter int BASE_HALF = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_slow,
  output logic sclk,
  output logic fall_tick
);
  localparam int CNT_W = $clog2(BASE_HALF + 1);
  localparam logic [CNT_W:0] LAST_FAST = (CNT_W + 1)'(BASE_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   last;
  logic             wrap;

  assign last      = LAST_FAST + {{CNT_W{1'b0}}, sel_slow};
  assign wrap      = {1'b0, cnt} >= last;
  assign fall_tick = wrap & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lfr_phase_seq.sv
// Counts serial clock periods; derives carrier, conversion clock and shift strobes.
module lfr_phase_seq #(
  parameter int CONV_SCLKS    = 16,
  parameter int CARRIER_SCLKS = 8,
  parameter int DATA_W        = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_tick,
  output logic adc_clk,
  output logic carrier,
  output logic load_tick,
  output logic shift_tick,
  output logic end_tick
);
  localparam int PH_W    = $clog2(CONV_SCLKS);
  localparam int CAR_BIT = $clog2(CARRIER_SCLKS) - 1;
  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(CONV_SCLKS - 1);
  localparam logic [PH_W-1:0] PH_ADC_OFF = PH_W'(CONV_SCLKS / 2);
  localparam logic [PH_W-1:0] PH_END     = PH_W'(DATA_W);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nxt;

  assign ph_nxt     = ph + 1'b1;
  assign load_tick  = fall_tick && (ph_nxt == '0);
  assign shift_tick = fall_tick && (ph_nxt != '0) && (ph_nxt < PH_END);
  assign end_tick   = fall_tick && (ph_nxt == PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_LAST;
      adc_clk <= 1'b0;
      carrier <= 1'b0;
    end else if (fall_tick) begin
      ph      <= ph_nxt;
      adc_clk <= ph_nxt < PH_ADC_OFF;
      carrier <= ph_nxt[CAR_BIT];
    end
  end
endmodule

// File: rtl/lfr_shifter.sv
// Captures the sample at the load strobe and shifts it out MSB first.
module lfr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_tick,
  input  logic              shift_tick,
  input  logic              end_tick,
  input  logic [DATA_W-1:0] sample,
  output logic              frame,
  output logic              sdata
);
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      frame <= 1'b0;
      sdata <= 1'b0;
    end else if (load_tick) begin
      hold  <= {sample[DATA_W-2:0], 1'b0};
      sdata <= sample[DATA_W-1];
      frame <= 1'b1;
    end else if (shift_tick) begin
      hold  <= {hold[DATA_W-2:0], 1'b0};
      sdata <= hold[DATA_W-1];
    end else if (end_tick) begin
      sdata <= 1'b0;
      frame <= 1'b0;
    end
  end
endmodule

// File: rtl/lf_reader_front.sv
module lf_reader_front #(
  parameter int DATA_W        = 8,
  parameter int DIV_W         = 8,
  parameter int BASE_HALF     = 11,
  parameter int CONV_SCLKS    = 16,
  parameter int CARRIER_SCLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_d,
  input  logic              sel_125k,
  input  logic [DIV_W-1:0]  divisor,
  output logic              carrier_lo,
  output logic              carrier_hi,
  output logic              adc_clk,
  output logic              ser_clk,
  output logic              ser_frame,
  output logic              ser_data,
  output logic              dbg_adc_clk
);
  logic fall_tick;
  logic load_tick;
  logic shift_tick;
  logic end_tick;

  lfr_sclk_gen #(.BASE_HALF(BASE_HALF)) u_sclk (
    .clk(clk), .rst(rst), .sel_slow(sel_125k),
    .sclk(ser_clk), .fall_tick(fall_tick)
  );

  lfr_phase_seq #(
    .CONV_SCLKS(CONV_SCLKS), .CARRIER_SCLKS(CARRIER_SCLKS), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .fall_tick(fall_tick),
    .adc_clk(adc_clk), .carrier(carrier_lo),
    .load_tick(load_tick), .shift_tick(shift_tick), .end_tick(end_tick)
  );

  lfr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_tick(load_tick), .shift_tick(shift_tick),
    .end_tick(end_tick), .sample(adc_d), .frame(ser_frame), .sdata(ser_data)
  );

  assign carrier_hi  = 1'b0;
  assign dbg_adc_clk = adc_clk;
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
  parameter int BASE_HALF = 11,
  parameter int DIV_W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_125k,
  input logic [DIV_W-1:0] divisor,
  input logic             ser_clk,
  input logic             carrier_lo,
  input logic             adc_clk,
  input logic             ser_frame,
  input logic             ser_data
);
  import lfr_pkg::*;
  localparam int RUN_W = $clog2(BASE_HALF + 3) + 1;

  logic [RUN_W-1:0] run;
  logic             prev_sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= RUN_W'(1);
      prev_sclk <= 1'b0;
    end else begin
      prev_sclk <= ser_clk;
      run       <= (ser_clk != prev_sclk) ? RUN_W'(1) : run + 1'b1;
    end
  end

  assert_sclk_run_R1: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_W'(BASE_HALF + 2));
  assert_sel_steady_R1: assert property (@(posedge clk) disable iff (rst)
    $stable(sel_125k));
  assert_carrier_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (carrier_lo != $past(carrier_lo)) |-> $fell(ser_clk));
  assert_frame_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_frame) |-> $rose(adc_clk));
  assert_data_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_data != $past(ser_data)) |-> $fell(ser_clk));
  assert_data_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ser_frame |-> !ser_data);
  assert_divisor_range_R9: assert property (@(posedge clk) disable iff (rst)
    divisor >= DIV_W'(LFR_DIV_MIN));
endmodule

bind lf_reader_front lfr_checker #(.BASE_HALF(BASE_HALF), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sel_125k(sel_125k), .divisor(divisor),
  .ser_clk(ser_clk), .carrier_lo(carrier_lo), .adc_clk(adc_clk),
  .ser_frame(ser_frame), .ser_data(ser_data)
);

// File: tb/lf_reader_front_test.sv
module lf_reader_front_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] adc_d = 8'h00;
  logic       sel = 1'b1;
  logic [7:0] divisor = 8'd95;
  logic carrier_lo, carrier_hi, adc_clk, ser_clk, ser_frame, ser_data, dbg_adc_clk;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lf_reader_front uut (
    .clk(clk), .rst(rst), .adc_d(adc_d), .sel_125k(sel), .divisor(divisor),
    .carrier_lo(carrier_lo), .carrier_hi(carrier_hi), .adc_clk(adc_clk),
    .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_data(ser_data),
    .dbg_adc_clk(dbg_adc_clk)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit s, logic [7:0] dv);
    @(negedge clk);
    rst = 1'b1; sel = s; divisor = dv;
    repeat (4) @(negedge clk);
  endtask

  // R10 (and R9 when called with extreme divisors): reset state and first edges
  task automatic t_reset(bit s, logic [7:0] dv, string tag);
    int h = 11 + int'(s);
    int n = 0;
    do_reset(s, dv);
    chk({ser_clk, carrier_lo, adc_clk, ser_frame, ser_data} == 5'b0, tag,
        "outputs low in reset", int'({ser_clk, carrier_lo, adc_clk, ser_frame, ser_data}), 0);
    adc_d = 8'hC3;
    rst = 1'b0;
    do begin @(negedge clk); n++; end while (!ser_clk && n < 200);
    chk(n == h, tag, "first serial clock rise edge", n, h);
    do begin @(negedge clk); n++; end while (!ser_frame && n < 400);
    chk(n == 2 * h, tag, "first frame edge", n, 2 * h);
    chk(adc_clk == 1'b1, tag, "adc clock with first frame (R3)", int'(adc_clk), 1);
    chk(ser_data == 1'b1, tag, "first bit is sample MSB", int'(ser_data), 1);
  endtask

  // R1 R2 R3 R7 R8: periods and duty of generated clocks
  task automatic t_timing(bit s);
    int h = 11 + int'(s);
    int sr = -1, cr = -1, ar = -1;
    int s_per = 0, s_hi = 0, c_per = 0, c_hi = 0, a_per = 0, a_hi = 0;
    int bad_car = 0, bad_dbg = 0, bad_hi = 0;
    logic ps = 1'b0, pc = 1'b0, pa = 1'b0;
    do_reset(s, 8'd95);
    rst = 1'b0;
    for (int c = 1; c <= 100 * h; c++) begin
      @(negedge clk);
      if (ser_clk && !ps) begin if (sr >= 0) s_per = c - sr; sr = c; end
      if (!ser_clk && ps && sr >= 0) s_hi = c - sr;
      if (carrier_lo && !pc) begin if (cr >= 0) c_per = c - cr; cr = c; end
      if (!carrier_lo && pc && cr >= 0) c_hi = c - cr;
      if (carrier_lo != pc && !(ps && !ser_clk)) bad_car++;
      if (adc_clk && !pa) begin if (ar >= 0) a_per = c - ar; ar = c; end
      if (!adc_clk && pa && ar >= 0) a_hi = c - ar;
      if (dbg_adc_clk !== adc_clk) bad_dbg++;
      if (carrier_hi !== 1'b0) bad_hi++;
      ps = ser_clk; pc = carrier_lo; pa = adc_clk;
    end
    chk(s_per == 2 * h, "R1", "serial clock period", s_per, 2 * h);
    chk(s_hi == h, "R1", "serial clock high time", s_hi, h);
    chk(c_per == 16 * h, "R2", "carrier period", c_per, 16 * h);
    chk(c_hi == 8 * h, "R2", "carrier high time", c_hi, 8 * h);
    chk(bad_car == 0, "R2", "carrier changes off a serial clock fall", bad_car, 0);
    chk(a_per == 32 * h, "R3", "adc clock period", a_per, 32 * h);
    chk(a_hi == 16 * h, "R3", "adc clock high time", a_hi, 16 * h);
    chk(bad_dbg == 0, "R8", "debug copy mismatches", bad_dbg, 0);
    chk(bad_hi == 0, "R7", "high-side drive not low", bad_hi, 0);
  endtask

  task automatic wait_sclk_rise();
    logic p = ser_clk;
    forever begin
      @(negedge clk);
      if (ser_clk && !p) break;
      p = ser_clk;
    end
  endtask

  // R4 R5 R6: framing and bit order, with the bus changed mid-shift
  task automatic t_words(bit s, logic [7:0] dv, string tag);
    logic [7:0] vals [5] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h3C};
    do_reset(s, dv);
    adc_d = vals[0];
    rst = 1'b0;
    for (int w = 0; w < 5; w++) begin
      logic [7:0] expv;
      logic [7:0] got = 8'h00;
      int frame_bad = 0;
      logic pa = adc_clk;
      adc_d = vals[w];
      forever begin
        @(negedge clk);
        if (adc_clk && !pa) break;
        pa = adc_clk;
      end
      chk(ser_frame == 1'b1, "R4", "frame rises with adc clock", int'(ser_frame), 1);
      expv = adc_d;
      adc_d = ~adc_d ^ 8'h5A;
      for (int b = 0; b < 8; b++) begin
        wait_sclk_rise();
        if (!ser_frame) frame_bad++;
        got = {got[6:0], ser_data};
      end
      chk(frame_bad == 0, "R4", "frame low during a bit", frame_bad, 0);
      chk(got == expv, tag, "word (R5/R6, MSB first)", int'(got), int'(expv));
      wait_sclk_rise();
      chk(ser_frame == 1'b0, "R4", "frame after 8 bits", int'(ser_frame), 0);
      chk(ser_data == 1'b0, "R5", "data idle after frame", int'(ser_data), 0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset(1'b1, 8'd95, "R10");
    t_reset(1'b0, 8'd95, "R10");
    t_timing(1'b1);
    t_timing(1'b0);
    t_words(1'b1, 8'd95, "R5");
    t_words(1'b0, 8'd200, "R6");
    t_reset(1'b1, 8'd16, "R9");
    t_reset(1'b1, 8'd255, "R9");
    t_words(1'b1, 8'd16, "R9");
    t_words(1'b0, 8'd255, "R9");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule